// File: doc/BRIEF.md
# I/O Read to Sleep-Request Redirector

This block sits on a core's I/O read request path. Each read is checked against a small programmable window. A read that hits one of the three idle-level probe ports becomes an internal sleep request instead of a bus access. Any other read goes on to the system unchanged.

Software programs three settings through a small write port: the window base, the window range and a global enable. The probe at the base address asks for C3. The probe one address above asks for C6. The probe two addresses above asks for C7. A redirected read never reaches the system. The requester instead gets a zero-data completion strobe, so it does not stall. Every sleep request carries a substate of zero and a flag that allows an interrupt to wake the core even when interrupts are masked.

All outputs are registered and appear one clock after the request.

Top module: `ioslp_redirect`

## Requirements
- R1: While the enable setting is 0, every valid read is forwarded on `io_valid`/`io_addr`, and `slp_valid` stays low.
- R2: With enable set, a read at the base address gives `slp_cstate` = 3. A read at base+1 gives 6, and a read at base+2 gives 7.
- R3: A read is trapped only if its address is at or above the base and its distance above the base is at most the range value. The address comparison does not wrap past the top of the address space. Any address outside the window is forwarded.
- R4: An address inside the window that lies 3 or more above the base is forwarded as a normal read.
- R5: One cycle after a valid read, exactly one of `io_valid` and `slp_valid` is high. For a forwarded read, `io_addr` equals the read address.
- R6: Every sleep request has `slp_substate` = 0 and `slp_wake_masked` = 1 (the default of parameter `WAKE_MASKED`).
- R7: `cpl_valid` pulses with `cpl_data` = 0 in the same cycle as each sleep request. It stays low for forwarded reads.
- R8: The write port selects its target with `cfg_sel`: 0 = base, 1 = range, 2 = enable (bit 0 of the data), 3 = no effect. A write takes effect on the cycle after it. A read in the same cycle as a write is decoded with the old settings.
- R9: Reset clears all outputs to 0 and sets the base, range and enable settings to 0.
- R10: A cycle with `rd_valid` low produces no `io_valid`, `slp_valid` or `cpl_valid` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_sel | input | 2 | Setting select: 0 base, 1 range, 2 enable, 3 none |
| cfg_wdata | input | 16 | Setting write data |
| rd_valid | input | 1 | I/O read request valid |
| rd_addr | input | 16 | I/O read address |
| io_valid | output | 1 | Forwarded I/O read valid |
| io_addr | output | 16 | Forwarded I/O read address |
| slp_valid | output | 1 | Sleep request valid |
| slp_cstate | output | 4 | Requested C-state number (3, 6 or 7) |
| slp_substate | output | 4 | Requested substate, always 0 |
| slp_wake_masked | output | 1 | Wake on interrupt even if masked |
| cpl_valid | output | 1 | Dummy completion strobe for a redirected read |
| cpl_data | output | 32 | Dummy completion data, always 0 |

## Verification
Every result of this block is due exactly one rising edge after the input that causes it. This covers the forwarded read, the sleep request, the completion strobe and the effect of a setting write. The bench drives each vector on a falling edge and compares all outputs one time unit after the next rising edge. That settles every vector in a single cycle. Vectors that pair a setting write with a read confirm that the read sees the old settings. The next vector confirms that the new settings apply one cycle later.

// File: rtl/ioslp_pkg.sv
// Package: shared encodings for the I/O read to sleep-request redirector.
// Assumes: C-state numbers fit in CST_W bits; levels are indexed from 0 at the base.
package ioslp_pkg;

    localparam int CST_W = 4;
    localparam int SUB_W = 4;

    typedef enum logic [1:0] {
        CFG_BASE   = 2'd0,
        CFG_RANGE  = 2'd1,
        CFG_ENABLE = 2'd2,
        CFG_NONE   = 2'd3
    } cfg_sel_e;

    // Map a probe level index (offset from base) to its C-state number.
    function automatic logic [CST_W-1:0] level_cstate(input int idx);
        case (idx)
            0:       return CST_W'(3);
            1:       return CST_W'(6);
            default: return CST_W'(7);
        endcase
    endfunction

endpackage

// File: rtl/ioslp_cfg_regs.sv
// Module: holds the window base, window range and enable settings.
// Assumes: one setting is written per cycle; a write is visible the next cycle.
module ioslp_cfg_regs
    import ioslp_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] base_q,
    output logic [ADDR_W-1:0] range_q,
    output logic              en_q
);

    // Update the selected setting on a write; clear all settings on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            range_q <= '0;
            en_q    <= 1'b0;
        end else if (we) begin
            case (cfg_sel_e'(sel))
                CFG_BASE:   base_q  <= wdata;
                CFG_RANGE:  range_q <= wdata;
                CFG_ENABLE: en_q    <= wdata[0];
                default:    ;
            endcase
        end
    end

    assert_base_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == 2'd0) |=> (base_q == $past(wdata)))
        else $error("base write not applied next cycle");

    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!we || sel == 2'd3) |=> ($stable(base_q) && $stable(range_q) && $stable(en_q)))
        else $error("settings changed without a write");

endmodule

// File: rtl/ioslp_decode.sv
// Module: decides whether a read address is a trapped probe and which level it hits.
// Assumes: purely combinational; the window is [base, base+range] with no wrap.
module ioslp_decode
    import ioslp_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int NUM_LVL = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] range,
    input  logic              en,
    output logic              hit,
    output logic [CST_W-1:0]  cstate
);

    logic [ADDR_W:0]    diff;
    logic [ADDR_W-1:0]  off;
    logic               in_win;
    logic [NUM_LVL-1:0] lvl_hit;

    // Distance above the base, with a borrow bit to reject addresses below it.
    always_comb begin
        diff   = {1'b0, addr} - {1'b0, base};
        off    = diff[ADDR_W-1:0];
        in_win = !diff[ADDR_W] && (off <= range);
    end

    // One match line per probe level.
    for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
        assign lvl_hit[i] = (off == ADDR_W'(i));
    end

    // Combine enable, window and level match; select the level's C-state.
    always_comb begin
        hit    = en && in_win && (|lvl_hit);
        cstate = '0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (lvl_hit[i]) cstate = level_cstate(i);
        end
    end

endmodule

// File: rtl/ioslp_out_stage.sv
// Module: registers the decision into either a forwarded read or a sleep request plus completion.
// Assumes: hit and cstate are valid whenever rd_valid is high.
module ioslp_out_stage
    import ioslp_pkg::*;
#(
    parameter int   ADDR_W      = 16,
    parameter int   DATA_W      = 32,
    parameter logic WAKE_MASKED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              hit,
    input  logic [CST_W-1:0]  cstate,
    output logic              io_valid,
    output logic [ADDR_W-1:0] io_addr,
    output logic              slp_valid,
    output logic [CST_W-1:0]  slp_cstate,
    output logic [SUB_W-1:0]  slp_substate,
    output logic              slp_wake_masked,
    output logic              cpl_valid,
    output logic [DATA_W-1:0] cpl_data
);

    logic fwd;
    logic trap;

    // Split a valid read into its forwarded or redirected form.
    always_comb begin
        fwd  = rd_valid && !hit;
        trap = rd_valid && hit;
    end

    // Register one cycle of output; a redirected read never drives the forward port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_valid        <= 1'b0;
            io_addr         <= '0;
            slp_valid       <= 1'b0;
            slp_cstate      <= '0;
            slp_wake_masked <= 1'b0;
            cpl_valid       <= 1'b0;
        end else begin
            io_valid        <= fwd;
            io_addr         <= fwd ? rd_addr : '0;
            slp_valid       <= trap;
            slp_cstate      <= trap ? cstate : '0;
            slp_wake_masked <= trap && WAKE_MASKED;
            cpl_valid       <= trap;
        end
    end

    assign slp_substate = '0;
    assign cpl_data     = '0;

    assert_one_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_valid && slp_valid))
        else $error("read both forwarded and redirected");

    assert_cstate_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        slp_valid |-> (slp_cstate == 4'd3 || slp_cstate == 4'd6 || slp_cstate == 4'd7))
        else $error("illegal C-state on sleep request");

    assert_cpl_with_sleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(trap) |-> (cpl_valid && cpl_data == '0 && slp_valid))
        else $error("completion missing for redirected read");

endmodule

// File: rtl/ioslp_redirect.sv
// Module: top of the I/O read to sleep-request redirector.
// Assumes: one read request per cycle; setting writes and reads may share a cycle.
module ioslp_redirect
    import ioslp_pkg::*;
#(
    parameter int   ADDR_W      = 16,
    parameter int   DATA_W      = 32,
    parameter int   NUM_LVL     = 3,
    parameter logic WAKE_MASKED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              io_valid,
    output logic [ADDR_W-1:0] io_addr,
    output logic              slp_valid,
    output logic [3:0]        slp_cstate,
    output logic [3:0]        slp_substate,
    output logic              slp_wake_masked,
    output logic              cpl_valid,
    output logic [DATA_W-1:0] cpl_data
);

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] range_q;
    logic              en_q;
    logic              hit;
    logic [CST_W-1:0]  cstate;

    ioslp_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .sel     (cfg_sel),
        .wdata   (cfg_wdata),
        .base_q  (base_q),
        .range_q (range_q),
        .en_q    (en_q)
    );

    ioslp_decode #(.ADDR_W(ADDR_W), .NUM_LVL(NUM_LVL)) u_dec (
        .addr   (rd_addr),
        .base   (base_q),
        .range  (range_q),
        .en     (en_q),
        .hit    (hit),
        .cstate (cstate)
    );

    ioslp_out_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAKE_MASKED(WAKE_MASKED)) u_out (
        .clk             (clk),
        .rst_n           (rst_n),
        .rd_valid        (rd_valid),
        .rd_addr         (rd_addr),
        .hit             (hit),
        .cstate          (cstate),
        .io_valid        (io_valid),
        .io_addr         (io_addr),
        .slp_valid       (slp_valid),
        .slp_cstate      (slp_cstate),
        .slp_substate    (slp_substate),
        .slp_wake_masked (slp_wake_masked),
        .cpl_valid       (cpl_valid),
        .cpl_data        (cpl_data)
    );

    assert_disabled_forward_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !en_q) |=> (io_valid && !slp_valid && io_addr == $past(rd_addr)))
        else $error("read not forwarded while disabled");

    assert_forward_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !hit) |=> (io_valid && io_addr == $past(rd_addr)))
        else $error("forwarded read lost or altered");

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> (!io_valid && !slp_valid && !cpl_valid))
        else $error("output without a read");

    assert_sleep_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
        slp_valid |-> (slp_substate == 4'd0 && slp_wake_masked == WAKE_MASKED))
        else $error("sleep request fields wrong");

endmodule

// File: tb/ioslp_redirect_bench.sv
// Bench: walks a vector table, then checks reset behaviour directly.
module ioslp_redirect_bench;

    typedef struct packed {
        logic        we;
        logic [1:0]  sel;
        logic [15:0] wd;
        logic        rv;
        logic [15:0] ra;
        logic        eio;
        logic        eslp;
        logic [3:0]  ecst;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b1, 2'd0, 16'h0410, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd0, 4'd8},  // R8 base write
        '{1'b1, 2'd1, 16'h0002, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd0, 4'd8},  // R8 range write
        '{1'b0, 2'd0, 16'h0000, 1'b1, 16'h0410, 1'b1, 1'b0, 4'd0, 4'd1},  // R1 disabled
        '{1'b1, 2'd2, 16'h0001, 1'b1, 16'h0411, 1'b1, 1'b0, 4'd0, 4'd8},  // R8 old enable used
        '{1'b0, 2'd0, 16'h0000, 1'b1, 16'h0410, 1'b0, 1'b1, 4'd3, 4'd2},  // R2 C3
        '{1'b0, 2'd0, 16'h0000, 1'b1, 16'h0411, 1'b0, 1'b1, 4'd6, 4'd2},  // R2 C6
        '{1'b0, 2'd0, 16'h0000, 1'b1, 16'h0412, 1'b0, 1'b1, 4'd7, 4'd2},  // R2 C7
        '{1'b0, 2'd0, 16'h0000, 1'b1, 16'h040F, 1'b1, 1'b0, 4'd0, 4'd3},  // R3 below base
        '{1'b1, 2'd1, 16'h0001, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd0, 4'd10}, // R10 idle write
        '{1'b0, 2'd0, 16'h0000, 1'b1, 16'h0412, 1'b1, 1'b0, 4'd0, 4'd3},  // R3 past range
        '{1'b0, 2'd0, 16'h0000, 1'b1, 16'h0411, 1'b0, 1'b1, 4'd6, 4'd3},  // R3 at range edge
        '{1'b1, 2'd1, 16'hFFFF, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd0, 4'd8},  // R8 wide range
        '{1'b0, 2'd0, 16'h0000, 1'b1, 16'h0413, 1'b1, 1'b0, 4'd0, 4'd4},  // R4 unmapped offset
        '{1'b0, 2'd0, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd0, 4'd10}, // R10 idle
        '{1'b1, 2'd3, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd0, 4'd8},  // R8 select 3
        '{1'b0, 2'd0, 16'h0000, 1'b1, 16'h0410, 1'b0, 1'b1, 4'd3, 4'd8},  // R8 select 3 no effect
        '{1'b1, 2'd2, 16'h0000, 1'b1, 16'h0412, 1'b0, 1'b1, 4'd7, 4'd8},  // R8 old enable used
        '{1'b0, 2'd0, 16'h0000, 1'b1, 16'h0412, 1'b1, 1'b0, 4'd0, 4'd1},  // R1 now disabled
        '{1'b1, 2'd0, 16'hFFFE, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd0, 4'd8},  // R8 base near top
        '{1'b1, 2'd2, 16'h0001, 1'b0, 16'h0000, 1'b0, 1'b0, 4'd0, 4'd8},  // R8 enable
        '{1'b0, 2'd0, 16'h0000, 1'b1, 16'hFFFF, 1'b0, 1'b1, 4'd6, 4'd2},  // R2 top C6
        '{1'b0, 2'd0, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b0, 4'd0, 4'd3},  // R3 no wrap
        '{1'b0, 2'd0, 16'h0000, 1'b1, 16'hFFFE, 1'b0, 1'b1, 4'd3, 4'd5}   // R5 redirect, no io
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = '0;
    logic        rd_valid = 1'b0;
    logic [15:0] rd_addr = '0;
    logic        io_valid;
    logic [15:0] io_addr;
    logic        slp_valid;
    logic [3:0]  slp_cstate;
    logic [3:0]  slp_substate;
    logic        slp_wake_masked;
    logic        cpl_valid;
    logic [31:0] cpl_data;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    ioslp_redirect u_ioslp_redirect (
        .clk (clk), .rst_n (rst_n),
        .cfg_we (cfg_we), .cfg_sel (cfg_sel), .cfg_wdata (cfg_wdata),
        .rd_valid (rd_valid), .rd_addr (rd_addr),
        .io_valid (io_valid), .io_addr (io_addr),
        .slp_valid (slp_valid), .slp_cstate (slp_cstate),
        .slp_substate (slp_substate), .slp_wake_masked (slp_wake_masked),
        .cpl_valid (cpl_valid), .cpl_data (cpl_data)
    );

    // Compare every output against the expectation of one vector.
    task automatic check_out(input string tag, input vec_t v);
        logic ok;
        ok = (io_valid == v.eio) && (slp_valid == v.eslp) && (cpl_valid == v.eslp)
             && (cpl_data == 32'd0) && (slp_substate == 4'd0);
        if (v.eio && io_addr != v.ra) ok = 1'b0;
        if (v.eslp && (slp_cstate != v.ecst || slp_wake_masked != 1'b1)) ok = 1'b0;
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s R%0d: io=%b/%h slp=%b c=%0d sub=%0d wk=%b cpl=%b/%h exp io=%b/%h slp=%b c=%0d cpl=%b",
                     tag, v.req, io_valid, io_addr, slp_valid, slp_cstate, slp_substate,
                     slp_wake_masked, cpl_valid, cpl_data, v.eio, v.ra, v.eslp, v.ecst, v.eslp);
        end
    endtask

    // Drive one vector on a falling edge and check one unit after the next rising edge.
    task automatic apply(input string tag, input vec_t v);
        @(negedge clk);
        cfg_we = v.we; cfg_sel = v.sel; cfg_wdata = v.wd;
        rd_valid = v.rv; rd_addr = v.ra;
        @(posedge clk);
        #1;
        check_out(tag, v);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        vec_t quiet;
        vec_t pass410;
        quiet   = '{1'b0, 2'd0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, 4'd0, 4'd9};
        pass410 = '{1'b0, 2'd0, 16'h0, 1'b1, 16'h0410, 1'b1, 1'b0, 4'd0, 4'd9};

        // R9: outputs held at zero during reset, even with a read presented.
        rd_valid = 1'b1; rd_addr = 16'h0410;
        repeat (3) @(posedge clk);
        #1;
        check_out("reset_R9", quiet);
        @(negedge clk);
        rd_valid = 1'b0;
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply($sformatf("vec%0d", i), VECS[i]);
        end

        // R9: reset mid-run clears enable and base, so a former probe address is forwarded.
        @(negedge clk);
        cfg_we = 1'b0; rd_valid = 1'b0; rst_n = 1'b0;
        @(posedge clk);
        #1;
        check_out("midreset_R9", quiet);
        @(negedge clk);
        rst_n = 1'b1;
        apply("after_reset_R9", pass410);

        @(negedge clk);
        rd_valid = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule